// File: doc/BRIEF.md
# Self-Checked Linear Round Layer

This block carries out the linear part of a lightweight cipher round on a 16-cell state held as a 4x4 array, with a cell width of 4 or 8 bits. It first moves the cells to new positions by a fixed permutation. It then mixes each column with an involutive matrix: every output cell is the XOR of the other three cells in its column. The mixed state leaves through a register together with an error flag.

The block does not duplicate any logic to check itself. It compares cheap XOR signatures instead. The permutation only moves cells, so the XOR of all cells is the same before and after it. Each column of the mixing matrix also XORs to one. As a result, a column's XOR, and the XOR of the whole state, pass through the mixing step unchanged. The predicted signatures therefore come straight from the incoming state and need no extra arithmetic. A mode input picks between two checks. The first is a per-column check, joined by a whole-state check on the permutation. The second is a single check over the whole state from the block input to the mixed output. Two fault masks are XORed onto internal nets: one onto the permuted state and one onto the mixed state. They let fault-injection campaigns test the detectors.

Top module: `slc_round_layer`

## Requirements
- R1: One cycle after an edge at which `in_vld` is high, `out_vld` is high. After an edge at which `in_vld` is low, `out_vld` is low. A synchronous reset clears `out_vld`, `out_err` and `out_state` to zero.
- R2: Cell i sits at bits [i*CELL_W +: CELL_W], and its column is i/4. Cell i of the permuted state is input cell P[i], with P = 0,10,5,15,14,4,11,1,9,3,12,6,7,13,2,8.
- R3: With both masks zero, each output cell is the XOR of the other three cells in the same column of the permuted state.
- R4: With both masks zero, `out_err` stays low in both modes.
- R5: With `sig_mode`=0 (column mode), any single-bit fault on the mixed-state mask sets `out_err`. The detector is a per-column XOR comparison against the permuted state.
- R6: With `sig_mode`=1 (union mode), any single-bit fault on either mask sets `out_err`. The detector is one comparison of the XOR of all output cells against the XOR of all input cells.
- R7: With `sig_mode`=0, any single-bit fault on the permuted-state mask sets `out_err`. The detector compares the XOR of all cells before and after the permutation.
- R8: `out_err` is high only together with `out_vld`.
- R9: After an edge with `in_vld` low, `out_state` keeps its previous value, whatever the data, mode and mask inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input state valid |
| sig_mode | input | 1 | 0 = column signatures, 1 = union signature |
| in_state | input | 16*CELL_W | Incoming state, cell i at bits [i*CELL_W +: CELL_W] |
| flt_shuf | input | 16*CELL_W | Fault mask XORed onto the permuted state |
| flt_mix | input | 16*CELL_W | Fault mask XORed onto the mixed state |
| out_vld | output | 1 | Output state valid |
| out_state | output | 16*CELL_W | Registered mixed state |
| out_err | output | 1 | Registered error flag |

## Verification
The bench builds the block with CELL_W = 8. This gives 128 bit positions on each mask, and every one of them is swept as a single-bit fault in both modes. It also gives eight-bit cells, in which a double fault can land on the same bit of two cells in one column. That is the pattern that defeats an XOR signature, so the escape rates reported for random double faults are meaningful. Random states, together with the directed cases of an all-zero state, an all-ones state and a single lit cell, make every permutation source and every mixing term visible at the output.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int CELLS = ROWS * COLS;

  // source cell of permuted cell i
  function automatic int shuf_src(input int i);
    case (i)
      0: return 0;   1: return 10;  2: return 5;   3: return 15;
      4: return 14;  5: return 4;   6: return 11;  7: return 1;
      8: return 9;   9: return 3;   10: return 12; 11: return 6;
      12: return 7;  13: return 13; 14: return 2;  default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/slc_shuffle.sv
module slc_shuffle #(
  parameter int CELL_W = 8,
  localparam int ST_W = slc_pkg::CELLS * CELL_W
) (
  input  logic [ST_W-1:0] st_i,
  output logic [ST_W-1:0] st_o
);
  for (genvar i = 0; i < slc_pkg::CELLS; i++) begin : g_cell
    localparam int SRC = slc_pkg::shuf_src(i);
    assign st_o[i*CELL_W +: CELL_W] = st_i[SRC*CELL_W +: CELL_W];
  end
endmodule

// File: rtl/slc_mix.sv
module slc_mix #(
  parameter int CELL_W = 8,
  localparam int ST_W = slc_pkg::CELLS * CELL_W
) (
  input  logic [ST_W-1:0] st_i,
  output logic [ST_W-1:0] st_o
);
  localparam int ROWS = slc_pkg::ROWS;
  for (genvar c = 0; c < slc_pkg::COLS; c++) begin : g_col
    logic [CELL_W-1:0] col_x;
    always_comb begin
      col_x = '0;
      for (int r = 0; r < ROWS; r++) col_x ^= st_i[(c*ROWS+r)*CELL_W +: CELL_W];
    end
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      // XOR of the three other cells in the column
      assign st_o[(c*ROWS+r)*CELL_W +: CELL_W] = col_x ^ st_i[(c*ROWS+r)*CELL_W +: CELL_W];
    end
  end
endmodule

// File: rtl/slc_sig_check.sv
module slc_sig_check #(
  parameter int CELL_W = 8,
  localparam int ST_W = slc_pkg::CELLS * CELL_W
) (
  input  logic            union_mode,
  input  logic [ST_W-1:0] blk_in,
  input  logic [ST_W-1:0] mix_in,
  input  logic [ST_W-1:0] mix_out,
  output logic            err
);
  localparam int ROWS = slc_pkg::ROWS;
  localparam int COLS = slc_pkg::COLS;

  logic [CELL_W-1:0] sig_blk, sig_shuf, sig_out;
  logic [COLS-1:0]   col_bad;

  always_comb begin
    sig_blk  = '0;
    sig_shuf = '0;
    sig_out  = '0;
    for (int i = 0; i < slc_pkg::CELLS; i++) begin
      sig_blk  ^= blk_in[i*CELL_W +: CELL_W];
      sig_shuf ^= mix_in[i*CELL_W +: CELL_W];
      sig_out  ^= mix_out[i*CELL_W +: CELL_W];
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [CELL_W-1:0] pred, act;
    always_comb begin
      pred = '0;
      act  = '0;
      for (int r = 0; r < ROWS; r++) begin
        pred ^= mix_in[(c*ROWS+r)*CELL_W +: CELL_W];
        act  ^= mix_out[(c*ROWS+r)*CELL_W +: CELL_W];
      end
    end
    assign col_bad[c] = (pred != act);
  end

  always_comb begin
    if (union_mode) err = (sig_blk != sig_out);
    else            err = (sig_blk != sig_shuf) || (|col_bad);
  end
endmodule

// File: rtl/slc_round_layer.sv
module slc_round_layer #(
  parameter int CELL_W = 8,
  localparam int ST_W = slc_pkg::CELLS * CELL_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic            sig_mode,
  input  logic [ST_W-1:0] in_state,
  input  logic [ST_W-1:0] flt_shuf,
  input  logic [ST_W-1:0] flt_mix,
  output logic            out_vld,
  output logic [ST_W-1:0] out_state,
  output logic            out_err
);
  logic [ST_W-1:0] shuf_raw, shuf_f, mix_raw, mix_f;
  logic            chk_err;

  slc_shuffle #(.CELL_W(CELL_W)) u_shuf (.st_i(in_state), .st_o(shuf_raw));
  assign shuf_f = shuf_raw ^ flt_shuf;

  slc_mix #(.CELL_W(CELL_W)) u_mix (.st_i(shuf_f), .st_o(mix_raw));
  assign mix_f = mix_raw ^ flt_mix;

  slc_sig_check #(.CELL_W(CELL_W)) u_chk (
    .union_mode(sig_mode), .blk_in(in_state), .mix_in(shuf_f),
    .mix_out(mix_f), .err(chk_err));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_err   <= 1'b0;
      out_state <= '0;
    end else begin
      out_vld <= in_vld;
      out_err <= in_vld & chk_err;
      if (in_vld) out_state <= mix_f;
    end
  end
endmodule

// File: rtl/slc_round_layer_chk.sv
module slc_round_layer_chk #(
  parameter int CELL_W = 8,
  localparam int ST_W = slc_pkg::CELLS * CELL_W
) (
  input logic            clk,
  input logic            rst,
  input logic            in_vld,
  input logic [ST_W-1:0] flt_shuf,
  input logic [ST_W-1:0] flt_mix,
  input logic            out_vld,
  input logic [ST_W-1:0] out_state,
  input logic            out_err
);
  p_vld_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);
  p_vld_drop_r1: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);
  p_clean_r4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && flt_shuf == '0 && flt_mix == '0) |=> !out_err);
  // single mixed-state fault caught in both modes (R5, R6)
  p_single_mix_r5: assert property (@(posedge clk) disable iff (rst)
    (in_vld && flt_shuf == '0 && $countones(flt_mix) == 1) |=> out_err);
  // single permuted-state fault caught in both modes (R7, R6)
  p_single_shuf_r7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && flt_mix == '0 && $countones(flt_shuf) == 1) |=> out_err);
  p_err_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> !out_err);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_state));
endmodule

bind slc_round_layer slc_round_layer_chk #(.CELL_W(CELL_W)) u_assert (
  .clk(clk), .rst(rst), .in_vld(in_vld), .flt_shuf(flt_shuf),
  .flt_mix(flt_mix), .out_vld(out_vld), .out_state(out_state),
  .out_err(out_err));

// File: tb/test_slc_round_layer.sv
module test_slc_round_layer;
  localparam int CW = 8;
  localparam int NC = 16;
  localparam int SW = NC * CW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic sig_mode = 1'b0;
  logic [SW-1:0] in_state = '0, flt_shuf = '0, flt_mix = '0;
  logic out_vld, out_err;
  logic [SW-1:0] out_state;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slc_round_layer #(.CELL_W(CW)) i_slc_round_layer (
    .clk(clk), .rst(rst), .in_vld(in_vld), .sig_mode(sig_mode),
    .in_state(in_state), .flt_shuf(flt_shuf), .flt_mix(flt_mix),
    .out_vld(out_vld), .out_state(out_state), .out_err(out_err));

  function automatic logic [SW-1:0] exp_out(input logic [SW-1:0] s);
    int p[NC] = '{0,10,5,15,14,4,11,1,9,3,12,6,7,13,2,8};
    logic [SW-1:0] sh, o;
    for (int i = 0; i < NC; i++) sh[i*CW +: CW] = s[p[i]*CW +: CW];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [CW-1:0] x;
        x = '0;
        for (int k = 0; k < 4; k++)
          if (k != r) x ^= sh[(c*4+k)*CW +: CW];
        o[(c*4+r)*CW +: CW] = x;
      end
    return o;
  endfunction

  function automatic logic [SW-1:0] rnd_state();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                     input logic [SW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one vector, sample one cycle later away from the edge
  task automatic apply(input logic [SW-1:0] s, input logic m,
                       input logic [SW-1:0] fs, input logic [SW-1:0] fm);
    @(negedge clk);
    in_vld = 1'b1; sig_mode = m; in_state = s; flt_shuf = fs; flt_mix = fm;
    @(negedge clk);
    in_vld = 1'b0; flt_shuf = '0; flt_mix = '0;
  endtask

  task automatic clean_vec(input logic [SW-1:0] s, input logic m);
    logic [SW-1:0] e;
    e = exp_out(s);
    apply(s, m, '0, '0);
    chk(out_vld === 1'b1, "R1 out_vld", SW'(out_vld), SW'(1));
    chk(out_state === e, "R2/R3 state", out_state, e);
    chk(out_err === 1'b0, "R4 clean err", SW'(out_err), SW'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] s, held;
    int esc_col = 0, esc_uni = 0;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_vld === 1'b0, "R1 reset vld", SW'(out_vld), SW'(0));
    chk(out_err === 1'b0, "R1 reset err", SW'(out_err), SW'(0));
    chk(out_state === '0, "R1 reset state", out_state, '0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_vld === 1'b0, "R1 idle vld", SW'(out_vld), SW'(0));

    // directed corner states, both modes
    for (int m = 0; m < 2; m++) begin
      clean_vec('0, m[0]);
      clean_vec('1, m[0]);
      for (int i = 0; i < NC; i++) clean_vec(SW'({CW{1'b1}}) << (i*CW), m[0]); // R2 each source
    end
    // random clean vectors, R2 R3 R4
    for (int n = 0; n < 300; n++) clean_vec(rnd_state(), n[0]);

    // R9 hold with idle input and live masks; R8 err gated
    s = rnd_state();
    apply(s, 1'b0, '0, '0);
    held = out_state;
    @(negedge clk);
    in_vld = 1'b0; in_state = rnd_state(); flt_mix = 1; flt_shuf = 2; sig_mode = 1'b1;
    @(negedge clk);
    chk(out_state === held, "R9 hold", out_state, held);
    chk(out_vld === 1'b0, "R1 vld low", SW'(out_vld), SW'(0));
    chk(out_err === 1'b0, "R8 err without vld", SW'(out_err), SW'(0));
    flt_mix = '0; flt_shuf = '0;

    // single-bit sweeps
    for (int b = 0; b < SW; b++) begin
      apply(rnd_state(), 1'b0, '0, SW'(1) << b);
      chk(out_err === 1'b1, "R5 column mix fault", SW'(out_err), SW'(1));
      apply(rnd_state(), 1'b0, SW'(1) << b, '0);
      chk(out_err === 1'b1, "R7 column shuffle fault", SW'(out_err), SW'(1));
      apply(rnd_state(), 1'b1, '0, SW'(1) << b);
      chk(out_err === 1'b1, "R6 union mix fault", SW'(out_err), SW'(1));
      apply(rnd_state(), 1'b1, SW'(1) << b, '0);
      chk(out_err === 1'b1, "R6 union shuffle fault", SW'(out_err), SW'(1));
    end

    // random double faults on the mixed state: escape rates only
    for (int n = 0; n < 2000; n++) begin
      int b0, b1;
      logic [SW-1:0] fm;
      b0 = $urandom_range(SW-1);
      do b1 = $urandom_range(SW-1); while (b1 == b0);
      fm = (SW'(1) << b0) | (SW'(1) << b1);
      apply(rnd_state(), 1'b0, '0, fm);
      if (!out_err) esc_col++;
      apply(rnd_state(), 1'b1, '0, fm);
      if (!out_err) esc_uni++;
    end
    $display("double-fault escapes: column %0d/2000, union %0d/2000", esc_col, esc_uni);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule